// File: doc/BRIEF.md
# T1 Transmit Frame Timer

This block produces the transmit-side bit, channel, frame and multiframe timing for a 24-channel T1 line running at 1.544 MHz. A frame has 193 bit times: the framing bit comes first and is followed by 24 channels of 8 bits each. The block counts positions within a frame and frames within a multiframe. It takes its frame or multiframe boundary from an external sync pulse, or it drives a sync pulse out. During each channel it raises a blocking strobe taken from a programmable 24-bit mask. It produces a demand clock for an external link-data source, samples that link bit in the framing slot, and samples the serial payload in every channel bit.

The clock `clk` is the inverted line clock, so each rising edge of `clk` is a falling edge of the line clock, and that is where `serIn`, `linkIn` and `syncIn` are sampled. Software sets the framing format (12-frame superframe, 24-frame extended superframe, or the extended format with bit-stuffed link), the sync direction and the pulse options through a small write-only register port.

Top module: `t1_tx_frame_timer`

## Requirements
- R1: While `rstN` is low the block holds `bitIdx`=0 and `frameIdx`=0, `fBitSlot`=1, and `chanBlock`, `linkClk`, `syncOut`, `syncDrive`, `payloadValid` and `linkValid` at 0. All configuration and mask bits are cleared, so the format is the 12-frame one and the sync pin is an input.
- R2: `bitIdx` counts 0..192 and then wraps, with position 0 as the framing bit (`fBitSlot`=1). `frameIdx` counts frames from 0 and advances on each wrap. It returns to 0 after index 11 in the 12-frame format and after index 23 in the two 24-frame formats. Frame number N means `frameIdx`=N-1.
- R3: A write with `regWrEn`=1 takes effect from the next cycle. Address 0 is the control register: bit 0 = sync pin is output, bit 1 = sync marks multiframes, bit 2 = double-wide pulse, bit 3 = link sampling enable, bits 5:4 = format (00 12-frame, 01 24-frame, 10 24-frame with stuffed link, 11 acts as 01). Addresses 1, 2 and 3 hold the mask bytes, and bit i of address k controls channel 8*(k-1)+i+1.
- R4: In bit positions 8*(c-1)+1 .. 8*c, `chanBlock` equals the mask bit of channel c. It is 0 in the framing bit.
- R5: After every channel-bit position, `payloadValid` is 1 for one cycle with `payloadBit` equal to `serIn` as sampled in that position. After the framing bit, `payloadValid` is 0.
- R6: If link sampling is enabled and the framing bit belongs to a link frame, `linkValid` is 1 in the next cycle and `linkBit` equals the `linkIn` value sampled then. Link frames are the even-numbered frames in the 12-frame format, the odd-numbered frames in the 24-frame format, and frames 1, 5, 9, ... with the stuffed link. In every other cycle `linkValid` is 0.
- R7: `linkClk` is high during the last channel (positions 185..192) of every frame that is followed by a link frame. This gives one pulse every 2 frames (4 kHz) in the 12-frame and 24-frame formats and one every 4 frames (2 kHz) with the stuffed link. It does not depend on the link enable.
- R8: With the sync pin as input and frame-sync chosen, a cycle with `syncIn`=1 makes the next position the framing bit and advances `frameIdx` by one, with wrap. A pulse in position 192 therefore changes nothing.
- R9: With the sync pin as input and multiframe sync chosen, a cycle with `syncIn`=1 makes the next position the framing bit of frame index 0.
- R10: With the sync pin as output, `syncDrive` is 1, `syncIn` is ignored, and in frame-pulse mode `syncOut` is high during every framing bit. With the sync pin as input, `syncDrive` and `syncOut` are 0.
- R11: In frame-pulse output mode with the double-wide option, `syncOut` is also high in position 1 of signaling frames, which are the frames whose number is a multiple of 6.
- R12: In multiframe output mode, `syncOut` is high only in the framing bit of frame index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Inverted 1.544 MHz line clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 control, 1..3 mask bytes) |
| regWrData | input | 8 | Register write data |
| syncIn | input | 1 | External sync pulse (input mode) |
| serIn | input | 1 | Serial NRZ payload |
| linkIn | input | 1 | Link data bit |
| syncOut | output | 1 | Generated sync pulse |
| syncDrive | output | 1 | High when the sync pin is driven |
| chanBlock | output | 1 | Per-channel blocking strobe |
| linkClk | output | 1 | Link demand clock |
| fBitSlot | output | 1 | High in the framing-bit position |
| payloadBit | output | 1 | Last sampled payload bit |
| payloadValid | output | 1 | Payload bit sampled last cycle |
| linkBit | output | 1 | Last sampled link bit |
| linkValid | output | 1 | Link bit sampled last cycle |
| bitIdx | output | 8 | Bit position in frame (0 = framing bit) |
| frameIdx | output | 5 | Frame index in multiframe |

## Verification
The position counters, `fBitSlot`, `chanBlock`, `linkClk`, `syncOut` and `syncDrive` are decoded from the current position and configuration. They therefore change one edge after a register write or a sync pulse. `payloadValid`/`payloadBit` and `linkValid`/`linkBit` come one edge after the position in which their input was sampled. The bench keeps its own position, frame and configuration variables and updates them on each rising edge from the inputs that edge saw. It compares every output on the falling edge that follows, so each result is checked in exactly the cycle in which it is due. The explicit checks after a sync pulse or a write look at the first falling edge after the rising edge that used it.

// File: rtl/t1_tx_pkg.sv
package t1_tx_pkg;

  // Framing format selector, control register bits 5:4
  typedef enum logic [1:0] {
    FMT_D4     = 2'b00,
    FMT_ESF    = 2'b01,
    FMT_ZB     = 2'b10,
    FMT_ESF_B  = 2'b11
  } fmt_e;

  // Control register image, msb first so it maps to bits 5:0
  typedef struct packed {
    fmt_e fmt;
    logic linkEn;
    logic dblWide;
    logic mfSync;
    logic syncOut;
  } cfg_t;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic fSlot;
    logic secondBit;
    logic sigFrame;
    logic mfFirst;
    logic linkTake;
    logic linkDemand;
    logic payTake;
  } strobe_t;

endpackage

// File: rtl/t1_tx_ctrl.sv
module t1_tx_ctrl
  import t1_tx_pkg::*;
#(
  parameter int CHANNELS   = 24,
  parameter int CHAN_BITS  = 8,
  parameter int D4_FRAMES  = 12,
  parameter int ESF_FRAMES = 24,
  parameter int SIG_PERIOD = 6,
  parameter int FDL_STRIDE = 2,
  parameter int ZB_STRIDE  = 4,
  localparam int FRAME_BITS = CHANNELS * CHAN_BITS + 1,
  localparam int BIT_W = $clog2(FRAME_BITS),
  localparam int FRM_W = $clog2(ESF_FRAMES),
  localparam int CH_W  = $clog2(CHANNELS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  cfg_t             cfgData,
  input  logic             syncIn,
  output cfg_t             cfg,
  output strobe_t          strobe,
  output logic [CH_W-1:0]  chanSel,
  output logic [BIT_W-1:0] bitIdx,
  output logic [FRM_W-1:0] frameIdx
);

  localparam int CB_W = (CHAN_BITS > 1) ? $clog2(CHAN_BITS) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
  localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(CHANNELS - 1);
  localparam logic [CB_W-1:0]  LAST_CB  = CB_W'(CHAN_BITS - 1);
  localparam logic [FRM_W-1:0] D4_LAST  = FRM_W'(D4_FRAMES - 1);
  localparam logic [FRM_W-1:0] ESF_LAST = FRM_W'(ESF_FRAMES - 1);

  logic [CB_W-1:0]  chanBit;
  logic [FRM_W-1:0] lastFrame;
  logic [FRM_W-1:0] frameNext;
  logic             lastBit;
  logic             fSlot;
  logic             syncHit;

  // Link-carrying frame by zero-based index
  function automatic logic isLinkFrame(input fmt_e f, input logic [FRM_W-1:0] idx);
    int n;
    n = int'(idx);
    case (f)
      FMT_D4:  return (n % FDL_STRIDE) == (FDL_STRIDE - 1);
      FMT_ZB:  return (n % ZB_STRIDE) == 0;
      default: return (n % FDL_STRIDE) == 0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfg <= '0;
    else if (cfgWr) cfg <= cfgData;
  end

  always_comb begin
    lastFrame = (cfg.fmt == FMT_D4) ? D4_LAST : ESF_LAST;
    frameNext = (frameIdx >= lastFrame) ? '0 : frameIdx + 1'b1;
    lastBit   = (bitIdx == LAST_BIT);
    fSlot     = (bitIdx == '0);
    syncHit   = !cfg.syncOut && syncIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx   <= '0;
      frameIdx <= '0;
      chanSel  <= '0;
      chanBit  <= '0;
    end else if (syncHit) begin
      bitIdx   <= '0;
      chanSel  <= '0;
      chanBit  <= '0;
      frameIdx <= cfg.mfSync ? '0 : frameNext;
    end else begin
      bitIdx <= lastBit ? '0 : bitIdx + 1'b1;
      if (lastBit) frameIdx <= frameNext;
      if (!fSlot) begin
        if (chanBit == LAST_CB) begin
          chanBit <= '0;
          chanSel <= (chanSel == LAST_CH) ? '0 : chanSel + 1'b1;
        end else begin
          chanBit <= chanBit + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.fSlot      = fSlot;
    strobe.secondBit  = (bitIdx == BIT_W'(1));
    strobe.sigFrame   = ((int'(frameIdx) + 1) % SIG_PERIOD) == 0;
    strobe.mfFirst    = (frameIdx == '0);
    strobe.linkTake   = fSlot && cfg.linkEn && isLinkFrame(cfg.fmt, frameIdx);
    strobe.linkDemand = !fSlot && (chanSel == LAST_CH) && isLinkFrame(cfg.fmt, frameNext);
    strobe.payTake    = !fSlot;
  end

endmodule

// File: rtl/t1_tx_datapath.sv
module t1_tx_datapath
  import t1_tx_pkg::*;
#(
  parameter int CHANNELS = 24,
  localparam int MASK_BYTES = (CHANNELS + 7) / 8,
  localparam int AW   = $clog2(MASK_BYTES + 1),
  localparam int CH_W = $clog2(CHANNELS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWrEn,
  input  logic [AW-1:0]   regAddr,
  input  logic [7:0]      regWrData,
  input  logic            syncOutMode,
  input  logic            mfMode,
  input  logic            dblWide,
  input  strobe_t         strobe,
  input  logic [CH_W-1:0] chanSel,
  input  logic            serIn,
  input  logic            linkIn,
  output logic            chanBlock,
  output logic            syncOut,
  output logic            syncDrive,
  output logic            linkClk,
  output logic            fBitSlot,
  output logic            payloadBit,
  output logic            payloadValid,
  output logic            linkBit,
  output logic            linkValid
);

  logic [MASK_BYTES*8-1:0] maskFlat;

  for (genvar k = 0; k < MASK_BYTES; k++) begin : g_maskByte
    logic [7:0] byteReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) byteReg <= '0;
      else if (regWrEn && regAddr == AW'(k + 1)) byteReg <= regWrData;
    end
    assign maskFlat[8*k +: 8] = byteReg;
  end

  always_comb begin
    fBitSlot  = strobe.fSlot;
    chanBlock = !strobe.fSlot && maskFlat[chanSel];
    linkClk   = strobe.linkDemand;
    syncDrive = syncOutMode;
    if (!syncOutMode)
      syncOut = 1'b0;
    else if (mfMode)
      syncOut = strobe.fSlot && strobe.mfFirst;
    else
      syncOut = strobe.fSlot || (dblWide && strobe.sigFrame && strobe.secondBit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      payloadValid <= 1'b0;
      payloadBit   <= 1'b0;
      linkValid    <= 1'b0;
      linkBit      <= 1'b0;
    end else begin
      payloadValid <= strobe.payTake;
      if (strobe.payTake) payloadBit <= serIn;
      linkValid <= strobe.linkTake;
      if (strobe.linkTake) linkBit <= linkIn;
    end
  end

endmodule

// File: rtl/t1_tx_frame_timer.sv
module t1_tx_frame_timer
  import t1_tx_pkg::*;
#(
  parameter int CHANNELS   = 24,
  parameter int CHAN_BITS  = 8,
  parameter int D4_FRAMES  = 12,
  parameter int ESF_FRAMES = 24,
  parameter int SIG_PERIOD = 6,
  parameter int FDL_STRIDE = 2,
  parameter int ZB_STRIDE  = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWrEn,
  input  logic [$clog2((CHANNELS + 7) / 8 + 1)-1:0] regAddr,
  input  logic [7:0] regWrData,
  input  logic syncIn,
  input  logic serIn,
  input  logic linkIn,
  output logic syncOut,
  output logic syncDrive,
  output logic chanBlock,
  output logic linkClk,
  output logic fBitSlot,
  output logic payloadBit,
  output logic payloadValid,
  output logic linkBit,
  output logic linkValid,
  output logic [$clog2(CHANNELS * CHAN_BITS + 1)-1:0] bitIdx,
  output logic [$clog2(ESF_FRAMES)-1:0] frameIdx
);

  localparam int CH_W = $clog2(CHANNELS);

  cfg_t            cfg;
  strobe_t         strobe;
  logic [CH_W-1:0] chanSel;
  logic            cfgWr;

  assign cfgWr = regWrEn && (regAddr == '0);

  t1_tx_ctrl #(
    .CHANNELS(CHANNELS), .CHAN_BITS(CHAN_BITS), .D4_FRAMES(D4_FRAMES),
    .ESF_FRAMES(ESF_FRAMES), .SIG_PERIOD(SIG_PERIOD),
    .FDL_STRIDE(FDL_STRIDE), .ZB_STRIDE(ZB_STRIDE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgData(cfg_t'(regWrData[5:0])),
    .syncIn(syncIn), .cfg(cfg), .strobe(strobe), .chanSel(chanSel),
    .bitIdx(bitIdx), .frameIdx(frameIdx)
  );

  t1_tx_datapath #(.CHANNELS(CHANNELS)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .syncOutMode(cfg.syncOut), .mfMode(cfg.mfSync),
    .dblWide(cfg.dblWide), .strobe(strobe), .chanSel(chanSel),
    .serIn(serIn), .linkIn(linkIn), .chanBlock(chanBlock), .syncOut(syncOut),
    .syncDrive(syncDrive), .linkClk(linkClk), .fBitSlot(fBitSlot),
    .payloadBit(payloadBit), .payloadValid(payloadValid),
    .linkBit(linkBit), .linkValid(linkValid)
  );

endmodule

// File: rtl/t1_tx_frame_timer_chk.sv
module t1_tx_frame_timer_chk #(
  parameter int BIT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             syncIn,
  input logic             syncDrive,
  input logic             syncOut,
  input logic             fBitSlot,
  input logic             chanBlock,
  input logic             linkClk,
  input logic             payloadValid,
  input logic             linkValid,
  input logic [BIT_W-1:0] bitIdx
);

  assert_fbit_no_payload_R5: assert property (@(posedge clk) disable iff (!rstN)
    fBitSlot |=> !payloadValid);

  assert_chanbit_payload_R5: assert property (@(posedge clk) disable iff (!rstN)
    !fBitSlot |=> payloadValid);

  assert_link_after_fbit_R6: assert property (@(posedge clk) disable iff (!rstN)
    linkValid |-> $past(fBitSlot));

  assert_block_quiet_fbit_R4: assert property (@(posedge clk) disable iff (!rstN)
    fBitSlot |-> !chanBlock);

  assert_demand_outside_fbit_R7: assert property (@(posedge clk) disable iff (!rstN)
    fBitSlot |-> !linkClk);

  assert_sync_undriven_R10: assert property (@(posedge clk) disable iff (!rstN)
    !syncDrive |-> !syncOut);

  assert_realign_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!syncDrive && syncIn) |=> fBitSlot);

  assert_bit_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fBitSlot && !(syncIn && !syncDrive)) |=> (bitIdx == BIT_W'(1)));

  assert_wide_pulse_pos_R11: assert property (@(posedge clk) disable iff (!rstN)
    (syncOut && !fBitSlot) |-> (bitIdx == BIT_W'(1)));

endmodule

bind t1_tx_frame_timer t1_tx_frame_timer_chk #(.BIT_W(8)) u_chk (
  .clk(clk), .rstN(rstN), .syncIn(syncIn), .syncDrive(syncDrive),
  .syncOut(syncOut), .fBitSlot(fBitSlot), .chanBlock(chanBlock),
  .linkClk(linkClk), .payloadValid(payloadValid), .linkValid(linkValid),
  .bitIdx(bitIdx)
);

// File: tb/sim_t1_tx_frame_timer.sv
module sim_t1_tx_frame_timer;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic       syncIn = 1'b0, serIn = 1'b0, linkIn = 1'b0;
  logic       syncOut, syncDrive, chanBlock, linkClk, fBitSlot;
  logic       payloadBit, payloadValid, linkBit, linkValid;
  logic [7:0] bitIdx;
  logic [4:0] frameIdx;

  t1_tx_frame_timer u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .syncIn(syncIn), .serIn(serIn), .linkIn(linkIn),
    .syncOut(syncOut), .syncDrive(syncDrive), .chanBlock(chanBlock),
    .linkClk(linkClk), .fBitSlot(fBitSlot), .payloadBit(payloadBit),
    .payloadValid(payloadValid), .linkBit(linkBit), .linkValid(linkValid),
    .bitIdx(bitIdx), .frameIdx(frameIdx)
  );

  int checks = 0;
  int errors = 0;
  bit running = 0;
  bit done = 0;

  // Reference state
  int mBit = 0, mFrame = 0;
  logic [5:0] mCfg = '0;
  logic [23:0] mMask = '0;
  logic mPV = 0, mPB = 0, mLV = 0, mLB = 0;

  function automatic int lenOf(input logic [1:0] fmt);
    return (fmt == 2'b00) ? 12 : 24;
  endfunction

  function automatic bit linkNum(input logic [1:0] fmt, input int num);
    if (fmt == 2'b00) return (num % 2) == 0;
    if (fmt == 2'b10) return (num % 4) == 1;
    return (num % 2) == 1;
  endfunction

  function automatic int nextFrame(input int f, input logic [1:0] fmt);
    return (f + 1 >= lenOf(fmt)) ? 0 : f + 1;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Reference update on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mBit = 0; mFrame = 0; mCfg = '0; mMask = '0;
      mPV = 0; mPB = 0; mLV = 0; mLB = 0;
    end else begin
      if (mBit != 0) begin mPV = 1; mPB = serIn; end
      else mPV = 0;
      if (mBit == 0 && mCfg[3] && linkNum(mCfg[5:4], mFrame + 1)) begin
        mLV = 1; mLB = linkIn;
      end else mLV = 0;
      if (!mCfg[0] && syncIn) begin
        mBit = 0;
        mFrame = mCfg[1] ? 0 : nextFrame(mFrame, mCfg[5:4]);
      end else if (mBit == 192) begin
        mBit = 0;
        mFrame = nextFrame(mFrame, mCfg[5:4]);
      end else begin
        mBit = mBit + 1;
      end
      if (regWrEn) begin
        if (regAddr == 0) mCfg = regWrData[5:0];
        else mMask[8*(regAddr-1) +: 8] = regWrData;
      end
    end
  end

  // Every-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (rstN && running) begin
      int eBlk, eLclk, eSync;
      string sTag;
      eBlk  = (mBit != 0) ? int'(mMask[(mBit - 1) / 8]) : 0;
      eLclk = (mBit >= 185 && linkNum(mCfg[5:4], nextFrame(mFrame, mCfg[5:4]) + 1)) ? 1 : 0;
      if (!mCfg[0]) eSync = 0;
      else if (mCfg[1]) eSync = (mBit == 0 && mFrame == 0) ? 1 : 0;
      else eSync = (mBit == 0 || (mCfg[2] && ((mFrame + 1) % 6 == 0) && mBit == 1)) ? 1 : 0;
      sTag = mCfg[1] ? "R12" : (mCfg[2] ? "R11" : "R10");
      chk("R2", "bitIdx", int'(bitIdx), mBit);
      chk("R2", "frameIdx", int'(frameIdx), mFrame);
      chk("R2", "fBitSlot", int'(fBitSlot), (mBit == 0) ? 1 : 0);
      chk("R4", "chanBlock", int'(chanBlock), eBlk);
      chk("R7", "linkClk", int'(linkClk), eLclk);
      chk("R10", "syncDrive", int'(syncDrive), int'(mCfg[0]));
      chk(sTag, "syncOut", int'(syncOut), eSync);
      chk("R5", "payloadValid", int'(payloadValid), int'(mPV));
      if (mPV) chk("R5", "payloadBit", int'(payloadBit), int'(mPB));
      chk("R6", "linkValid", int'(linkValid), int'(mLV));
      if (mLV) chk("R6", "linkBit", int'(linkBit), int'(mLB));
    end
    serIn  <= 1'($urandom);
    linkIn <= 1'($urandom);
  end

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic waitFrames(input int n);
    repeat (n * 193) @(negedge clk);
  endtask

  task automatic waitPos(input int f, input int b);
    do @(negedge clk); while (!(mFrame == f && mBit == b));
  endtask

  task automatic waitBit(input int b);
    do @(negedge clk); while (mBit != b);
  endtask

  task automatic pulseSync();
    syncIn = 1'b1;
    @(negedge clk);
    syncIn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int expF;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "bitIdx", int'(bitIdx), 0);
    chk("R1", "frameIdx", int'(frameIdx), 0);
    chk("R1", "fBitSlot", int'(fBitSlot), 1);
    chk("R1", "chanBlock", int'(chanBlock), 0);
    chk("R1", "linkClk", int'(linkClk), 0);
    chk("R1", "syncOut", int'(syncOut), 0);
    chk("R1", "syncDrive", int'(syncDrive), 0);
    chk("R1", "payloadValid", int'(payloadValid), 0);
    chk("R1", "linkValid", int'(linkValid), 0);
    rstN = 1'b1;
    running = 1;

    // R3 mask bytes and 12-frame format with link enabled
    writeReg(2'd1, 8'hA5);
    writeReg(2'd2, 8'h3C);
    writeReg(2'd3, 8'h81);
    writeReg(2'd0, 8'b0000_1000);
    waitFrames(14);
    // 24-frame format
    writeReg(2'd0, 8'b0001_1000);
    waitFrames(26);
    // stuffed link format, 2 kHz demand
    writeReg(2'd0, 8'b0010_1000);
    waitFrames(10);
    // R3 format code 11 acts as 24-frame
    writeReg(2'd0, 8'b0011_1000);
    waitPos(23, 0);
    chk("R3", "frameIdx reaches 23 with code 11", int'(frameIdx), 23);
    waitFrames(2);

    // R8 frame sync input, misaligned then aligned
    writeReg(2'd0, 8'b0000_1000);
    waitBit(60);
    expF = nextFrame(mFrame, 2'b00);
    pulseSync();
    chk("R8", "bitIdx after realign", int'(bitIdx), 0);
    chk("R8", "frameIdx after realign", int'(frameIdx), expF);
    waitBit(192);
    expF = nextFrame(mFrame, 2'b00);
    pulseSync();
    chk("R8", "bitIdx aligned pulse", int'(bitIdx), 0);
    chk("R8", "frameIdx aligned pulse", int'(frameIdx), expF);
    waitFrames(2);

    // R9 multiframe sync input
    writeReg(2'd0, 8'b0001_1010);
    waitPos(7, 100);
    pulseSync();
    chk("R9", "bitIdx after mf sync", int'(bitIdx), 0);
    chk("R9", "frameIdx after mf sync", int'(frameIdx), 0);
    waitFrames(2);

    // R10 R11 frame-pulse output, double-wide, sync input ignored
    writeReg(2'd0, 8'b0000_1101);
    waitBit(50);
    pulseSync();
    chk("R10", "bitIdx with ignored sync", int'(bitIdx), 51);
    waitPos(5, 1);
    chk("R11", "syncOut in bit 1 of frame 6", int'(syncOut), 1);
    waitPos(6, 1);
    chk("R11", "syncOut in bit 1 of frame 7", int'(syncOut), 0);
    waitFrames(12);

    // R12 multiframe output in 24-frame format
    writeReg(2'd0, 8'b0001_1011);
    waitPos(0, 0);
    chk("R12", "syncOut at frame index 0", int'(syncOut), 1);
    waitPos(1, 0);
    chk("R12", "syncOut at frame index 1", int'(syncOut), 0);
    waitFrames(25);

    running = 0;
    finishRun();
  end

endmodule